// File: doc/BRIEF.md
# Boot Region Address Remap Decoder

This block decides, for every request presented to it, which memory or window an address belongs to. It keeps two separate views of the low boot region. One is for processor masters and one is for every other master (DMA engines, the bridge from programmable logic, debug). Each request carries a master-class flag that picks the view. The reply is a target code, the offset forwarded to that target, and a decode-error flag, all returned one clock after the request.

A small control word picks what sits at address 0 in each view. Processors see the boot ROM or the on-chip RAM there. Other masters see SDRAM or the on-chip RAM. The same word opens or hides two bridge windows. The word can only be written: its read port always returns zero, so software must keep its own copy of the value it last wrote. The boot ROM and the on-chip RAM also stay reachable at fixed addresses near the top of the map, whatever the control word holds.

Top module: `boot_remap_decoder`

## Requirements
- R1: A processor request (`req_cpu`=1) below 64 KB goes to the boot ROM (target 0) when control bit 0 is 0, and to the on-chip RAM (target 1) when it is 1. Bits 1 to 3 have no effect on this.
- R2: A non-processor request below 1 MiB goes to SDRAM (target 2) with offset equal to the address when control bit 1 is 0. When bit 1 is 1, such a request below 64 KB goes to the on-chip RAM. Bit 0 has no effect on this view.
- R3: Addresses 0xFFFD0000 to 0xFFFDFFFF always reach the boot ROM, and 0xFFFF0000 to 0xFFFFFFFF always reach the on-chip RAM, for both classes and any control value. The offset is the low 16 address bits.
- R4: Whenever a view maps the boot ROM or the on-chip RAM at 0, only the low 16 address bits are forwarded as the offset. In that case an address from 64 KB up to below 1 MiB returns a decode error.
- R5: Addresses 0xC0000000 to 0xFBFFFFFF go to the main bridge (target 3), with offset equal to the address minus 0xC0000000, when control bit 2 is 1. When bit 2 is 0 they return a decode error.
- R6: Addresses 0xFF200000 to 0xFF3FFFFF go to the lightweight bridge (target 4), with offset equal to the address minus 0xFF200000, when control bit 3 is 1. When bit 3 is 0 they return a decode error.
- R7: The control word is write-only: `cfg_rd_data` is zero at all times, including after writes.
- R8: After reset, `rsp_valid` is low and the control word is 0: boot ROM at 0 for processors, SDRAM at 0 for the others, and both bridges hidden.
- R9: A request accepted at a clock edge is answered (`rsp_valid`=1) at the next edge. A control write takes effect for requests presented in the following cycle.
- R10: A decode error reports target 5 with offset 0.
- R11: For both classes, addresses from 1 MiB up to below 0xC0000000 go to SDRAM with offset equal to the address. Any address not covered by the other rules goes to "other" (target 5) with no error, and the offset equals the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 4 | {lw bridge visible, main bridge visible, others: RAM at 0, processor: RAM at 0} |
| cfg_rd_data | output | 32 | Read data of the control word, always zero |
| req_valid | input | 1 | Request present |
| req_cpu | input | 1 | 1 = processor master, 0 = other master |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Registered reply valid |
| rsp_target | output | 3 | 0 ROM, 1 on-chip RAM, 2 SDRAM, 3 bridge, 4 lw bridge, 5 other |
| rsp_err | output | 1 | Decode error |
| rsp_offset | output | 32 | Offset forwarded to the target |

## Verification
The assertions assume that `req_cpu` and `req_addr` are known whenever `req_valid` is high, and that nothing is presented during reset. They also assume that a control write and a request landing in the same cycle are decoded with the old control value. The stimulus drives every input on the falling edge and raises `req_valid` only after reset has been released. It always issues a control write at least one full cycle before the request that depends on it, so each reply can be tied to a single known control value.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

  typedef enum logic [2:0] {
    TGT_ROM   = 3'd0,
    TGT_OCRAM = 3'd1,
    TGT_SDRAM = 3'd2,
    TGT_HBR   = 3'd3,
    TGT_LBR   = 3'd4,
    TGT_OTHER = 3'd5
  } target_e;

  typedef struct packed {
    logic lbr_vis;
    logic hbr_vis;
    logic dma_ocram;
    logic cpu_ocram;
  } remap_ctrl_t;

  localparam int CTRL_W = $bits(remap_ctrl_t);

endpackage

// File: rtl/remap_ctrl_reg.sv
module remap_ctrl_reg
  import bootmap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output remap_ctrl_t       ctrl,
  output logic [DATA_W-1:0] rd_data
);

  remap_ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= remap_ctrl_t'(wr_data);
    end
  end

  assign ctrl    = ctrl_q;
  // the register has no read path
  assign rd_data = '0;

endmodule

// File: rtl/boot_view_decoder.sv
module boot_view_decoder
  import bootmap_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter bit          CPU_VIEW   = 1'b1,
  parameter int          BOOT_W     = 16,
  parameter logic [31:0] ALIAS_TOP  = 32'h0010_0000,
  parameter logic [31:0] SDRAM_TOP  = 32'hC000_0000,
  parameter logic [31:0] HBR_TOP    = 32'hFC00_0000,
  parameter logic [31:0] LBR_BASE   = 32'hFF20_0000,
  parameter int          LBR_W      = 21,
  parameter logic [31:0] ROM_HI     = 32'hFFFD_0000,
  parameter logic [31:0] OCRAM_HI   = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              zero_ocram,
  input  logic              hbr_vis,
  input  logic              lbr_vis,
  output target_e           tgt,
  output logic              err,
  output logic [ADDR_W-1:0] off
);

  localparam logic [ADDR_W-1:0] A_ALIAS = ADDR_W'(ALIAS_TOP);
  localparam logic [ADDR_W-1:0] A_SDRAM = ADDR_W'(SDRAM_TOP);
  localparam logic [ADDR_W-1:0] A_HBR   = ADDR_W'(HBR_TOP);
  localparam logic [ADDR_W-1:0] A_LBR   = ADDR_W'(LBR_BASE);
  localparam int                HI_W    = ADDR_W - BOOT_W;
  localparam logic [HI_W-1:0]   ROM_TAG = ROM_HI[ADDR_W-1:BOOT_W];
  localparam logic [HI_W-1:0]   RAM_TAG = OCRAM_HI[ADDR_W-1:BOOT_W];
  localparam int                LTAG_W  = ADDR_W - LBR_W;

  logic [ADDR_W-1:0] low_off;
  logic              in_boot_win;
  logic              in_lbr;
  target_e           boot_dev;

  assign low_off     = {{HI_W{1'b0}}, addr[BOOT_W-1:0]};
  assign in_boot_win = (addr[ADDR_W-1:BOOT_W] == '0);
  assign in_lbr      = (addr[ADDR_W-1:LBR_W] == A_LBR[ADDR_W-1:LBR_W]);
  assign boot_dev    = zero_ocram ? TGT_OCRAM : TGT_ROM;

  always_comb begin
    tgt = TGT_OTHER;
    err = 1'b0;
    off = addr;
    if (addr < A_ALIAS) begin
      if (!CPU_VIEW && !zero_ocram) begin
        tgt = TGT_SDRAM;
      end else if (in_boot_win) begin
        tgt = boot_dev;
        off = low_off;
      end else begin
        err = 1'b1;
      end
    end else if (addr < A_SDRAM) begin
      tgt = TGT_SDRAM;
    end else if (addr < A_HBR) begin
      if (hbr_vis) begin
        tgt = TGT_HBR;
        off = addr - A_SDRAM;
      end else begin
        err = 1'b1;
      end
    end else if (in_lbr) begin
      if (lbr_vis) begin
        tgt = TGT_LBR;
        off = {{LTAG_W{1'b0}}, addr[LBR_W-1:0]};
      end else begin
        err = 1'b1;
      end
    end else if (addr[ADDR_W-1:BOOT_W] == ROM_TAG) begin
      tgt = TGT_ROM;
      off = low_off;
    end else if (addr[ADDR_W-1:BOOT_W] == RAM_TAG) begin
      tgt = TGT_OCRAM;
      off = low_off;
    end
    if (err) begin
      tgt = TGT_OTHER;
      off = '0;
    end
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import bootmap_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          BOOT_W    = 16,
  parameter logic [31:0] ALIAS_TOP = 32'h0010_0000,
  parameter logic [31:0] SDRAM_TOP = 32'hC000_0000,
  parameter logic [31:0] HBR_TOP   = 32'hFC00_0000,
  parameter logic [31:0] LBR_BASE  = 32'hFF20_0000,
  parameter int          LBR_W     = 21,
  parameter logic [31:0] ROM_HI    = 32'hFFFD_0000,
  parameter logic [31:0] OCRAM_HI  = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [3:0]        cfg_wr_data,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              req_valid,
  input  logic              req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_target,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] rsp_offset
);

  localparam int N_VIEW = 2;  // view 0: processors, view 1: others
  localparam int HI_W   = ADDR_W - BOOT_W;

  remap_ctrl_t       ctrl;
  target_e           tgt_v [N_VIEW];
  logic              err_v [N_VIEW];
  logic [ADDR_W-1:0] off_v [N_VIEW];

  remap_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .ctrl    (ctrl),
    .rd_data (cfg_rd_data)
  );

  for (genvar g = 0; g < N_VIEW; g++) begin : g_view
    boot_view_decoder #(
      .ADDR_W    (ADDR_W),
      .CPU_VIEW  (g == 0),
      .BOOT_W    (BOOT_W),
      .ALIAS_TOP (ALIAS_TOP),
      .SDRAM_TOP (SDRAM_TOP),
      .HBR_TOP   (HBR_TOP),
      .LBR_BASE  (LBR_BASE),
      .LBR_W     (LBR_W),
      .ROM_HI    (ROM_HI),
      .OCRAM_HI  (OCRAM_HI)
    ) u_dec (
      .addr       (req_addr),
      .zero_ocram ((g == 0) ? ctrl.cpu_ocram : ctrl.dma_ocram),
      .hbr_vis    (ctrl.hbr_vis),
      .lbr_vis    (ctrl.lbr_vis),
      .tgt        (tgt_v[g]),
      .err        (err_v[g]),
      .off        (off_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_target <= TGT_OTHER;
      rsp_err    <= 1'b0;
      rsp_offset <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_target <= req_cpu ? tgt_v[0] : tgt_v[1];
        rsp_err    <= req_cpu ? err_v[0] : err_v[1];
        rsp_offset <= req_cpu ? off_v[0] : off_v[1];
      end
    end
  end

  // R9: one-cycle reply
  p_reply_next_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R10: error reply formatting
  p_err_format_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_target == 3'(TGT_OTHER) && rsp_offset == '0));

  // R3: fixed high alias of the boot ROM
  p_rom_high_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[ADDR_W-1:BOOT_W] == ROM_HI[ADDR_W-1:BOOT_W])
    |=> (rsp_target == 3'(TGT_ROM) && !rsp_err));

  // R3: fixed high alias of the on-chip RAM
  p_ram_high_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[ADDR_W-1:BOOT_W] == OCRAM_HI[ADDR_W-1:BOOT_W])
    |=> (rsp_target == 3'(TGT_OCRAM) && !rsp_err));

  // R4: boot devices never see more than the low window
  p_boot_window_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_target == 3'(TGT_ROM) || rsp_target == 3'(TGT_OCRAM)))
    |-> (rsp_offset[ADDR_W-1:BOOT_W] == {HI_W{1'b0}}));

  // R5: hidden main bridge produces a decode error
  p_hbr_hidden_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ctrl.hbr_vis && req_addr >= ADDR_W'(SDRAM_TOP) && req_addr < ADDR_W'(HBR_TOP))
    |=> rsp_err);

  // R6: lightweight bridge target only when visible
  p_lbr_vis_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_target == 3'(TGT_LBR)) |-> $past(ctrl.lbr_vis));

endmodule

// File: tb/boot_remap_decoder_tb.sv
module boot_remap_decoder_tb;

  localparam int NV = 25;
  // {req[3:0], cfg[3:0], cpu, addr[31:0], tgt[2:0], err, off[31:0]}
  localparam logic [76:0] VEC [NV] = '{
    {4'd1,  4'h0, 1'b1, 32'h0000_1234, 3'd0, 1'b0, 32'h0000_1234}, // R1
    {4'd4,  4'h0, 1'b1, 32'h0001_0000, 3'd5, 1'b1, 32'h0000_0000}, // R4
    {4'd4,  4'h0, 1'b1, 32'h000F_FFFF, 3'd5, 1'b1, 32'h0000_0000}, // R4
    {4'd2,  4'h0, 1'b0, 32'h0000_1234, 3'd2, 1'b0, 32'h0000_1234}, // R2
    {4'd2,  4'h0, 1'b0, 32'h0008_0000, 3'd2, 1'b0, 32'h0008_0000}, // R2
    {4'd11, 4'h0, 1'b1, 32'h0010_0000, 3'd2, 1'b0, 32'h0010_0000}, // R11
    {4'd11, 4'h0, 1'b0, 32'hBFFF_FFFC, 3'd2, 1'b0, 32'hBFFF_FFFC}, // R11
    {4'd5,  4'h0, 1'b1, 32'hC000_0000, 3'd5, 1'b1, 32'h0000_0000}, // R5
    {4'd6,  4'h0, 1'b0, 32'hFF20_0010, 3'd5, 1'b1, 32'h0000_0000}, // R6
    {4'd3,  4'h0, 1'b1, 32'hFFFD_0100, 3'd0, 1'b0, 32'h0000_0100}, // R3
    {4'd3,  4'h0, 1'b0, 32'hFFFF_FFF0, 3'd1, 1'b0, 32'h0000_FFF0}, // R3
    {4'd11, 4'h0, 1'b1, 32'hFF00_0000, 3'd5, 1'b0, 32'hFF00_0000}, // R11
    {4'd1,  4'h1, 1'b1, 32'h0000_ABCD, 3'd1, 1'b0, 32'h0000_ABCD}, // R1
    {4'd3,  4'h1, 1'b1, 32'hFFFD_0004, 3'd0, 1'b0, 32'h0000_0004}, // R3
    {4'd2,  4'h1, 1'b0, 32'h0000_0040, 3'd2, 1'b0, 32'h0000_0040}, // R2
    {4'd2,  4'h2, 1'b0, 32'h0000_0040, 3'd1, 1'b0, 32'h0000_0040}, // R2
    {4'd4,  4'h2, 1'b0, 32'h0002_0000, 3'd5, 1'b1, 32'h0000_0000}, // R4
    {4'd1,  4'h2, 1'b1, 32'h0000_0040, 3'd0, 1'b0, 32'h0000_0040}, // R1
    {4'd5,  4'h4, 1'b1, 32'hC123_4560, 3'd3, 1'b0, 32'h0123_4560}, // R5
    {4'd5,  4'h4, 1'b0, 32'hFBFF_FFFC, 3'd3, 1'b0, 32'h3BFF_FFFC}, // R5
    {4'd6,  4'h4, 1'b1, 32'hFF20_0000, 3'd5, 1'b1, 32'h0000_0000}, // R6
    {4'd6,  4'h8, 1'b0, 32'hFF3F_FFF0, 3'd4, 1'b0, 32'h001F_FFF0}, // R6
    {4'd5,  4'h8, 1'b1, 32'hC000_0000, 3'd5, 1'b1, 32'h0000_0000}, // R5
    {4'd11, 4'h8, 1'b1, 32'hFF40_0000, 3'd5, 1'b0, 32'hFF40_0000}, // R11
    {4'd11, 4'hF, 1'b1, 32'hFFFE_0000, 3'd5, 1'b0, 32'hFFFE_0000}  // R11
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        req_valid = 1'b0;
  logic        req_cpu = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_target;
  logic        rsp_err;
  logic [31:0] rsp_offset;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  boot_remap_decoder u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_cpu(req_cpu), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_err(rsp_err),
    .rsp_offset(rsp_offset)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  // issue one request and sample the reply just after the next rising edge
  task automatic request(input logic cpu, input logic [31:0] a,
                         output logic [37:0] r);
    @(negedge clk);
    req_valid = 1'b1;
    req_cpu   = cpu;
    req_addr  = a;
    @(posedge clk);
    #1;
    r = {rsp_valid, rsp_target, rsp_err, rsp_offset[31:0], 1'b0};
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [37:0] r;
    logic [3:0]  cur;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check("R8 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R7 read data at reset", 64'(cfg_rd_data), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    // R8: defaults without any write
    request(1'b1, 32'h0000_0010, r);
    check("R8 cpu default ROM", 64'(r[37:1]), 64'({1'b1, 3'd0, 1'b0, 32'h10}));
    request(1'b0, 32'h0000_0010, r);
    check("R8 dma default SDRAM", 64'(r[37:1]), 64'({1'b1, 3'd2, 1'b0, 32'h10}));
    request(1'b1, 32'hC000_0100, r);
    check("R8 bridge hidden", 64'(r[37:1]), 64'({1'b1, 3'd5, 1'b1, 32'h0}));

    cur = 4'h0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72:69] != cur) begin
        cur = VEC[i][72:69];
        write_cfg(cur);
      end
      request(VEC[i][68], VEC[i][67:36], r);
      check($sformatf("R%0d vector %0d", VEC[i][76:73], i), 64'(r[37:1]),
            64'({1'b1, VEC[i][35:33], VEC[i][32], VEC[i][31:0]}));
    end

    // R7: write-only, read side stays zero after nonzero writes
    write_cfg(4'hF);
    check("R7 read data after write", 64'(cfg_rd_data), 64'd0);

    // R9: idle cycle gives no reply
    @(posedge clk);
    #1;
    check("R9 no request no reply", 64'(rsp_valid), 64'd0);

    // R9: write in one cycle, request in the next uses the new value
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = 4'h0;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    req_valid = 1'b1;
    req_cpu   = 1'b1;
    req_addr  = 32'h0000_0020;
    @(posedge clk);
    #1;
    check("R9 new control applies next cycle", 64'({rsp_valid, rsp_target, rsp_err}),
          64'({1'b1, 3'd0, 1'b0}));
    @(negedge clk);
    req_valid = 1'b0;

    // R8: reset restores defaults after a full enable
    write_cfg(4'hF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    request(1'b0, 32'hFF20_0000, r);
    check("R8 reset hides lw bridge", 64'(r[37:1]), 64'({1'b1, 3'd5, 1'b1, 32'h0}));
    request(1'b1, 32'h0000_0004, r);
    check("R8 reset returns ROM at 0", 64'(r[37:1]), 64'({1'b1, 3'd0, 1'b0, 32'h4}));

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule